// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block is the control front end of a four-input analog-to-digital converter. It holds one 8-bit mode control word. The word chooses a fixed channel or a scan, enables the external trigger, gates the reference and decides whether conversion keeps running while the chip is in its low-power idle state. A software start strobe, or a rising edge on the external trigger pin, launches a sequence. For each channel the block drives the multiplexer select, issues a one-cycle convert request and waits for the converter core's done handshake before it moves on.

A scan always begins at input 0 and climbs to the selected channel. A fixed-channel conversion uses the selected input only. The trigger pin is shared with analog input 3. While the trigger is enabled, channel code 3 is therefore illegal, and so are the reserved codes 4 to 7. A start while the reference is off is refused. All of these illegal cases raise the error flag and produce no convert request.

Top module: `adc_scan_seq`

## Requirements
- R1: The control word resets to 0x00 and reads back what was written. Its bits are: [2:0] channel code, [3] scan enable, [4] trigger enable, [5] run-in-idle, [6] reference on. Bit 7 always reads 0.
- R2: In fixed mode with a legal code c (0..3), one start gives exactly one convert request, with channel output equal to c.
- R3: In scan mode with a legal code c, one start gives c+1 convert requests, on channels 0, 1, ..., c in that order.
- R4: Channel codes 4 to 7 drive the error output high, and a start then gives no convert request.
- R5: Code 3 with the trigger enable at 1 drives the error output high, and a start then gives no convert request.
- R6: A start while the reference bit is 0 gives no convert request and sets the error output. The error output stays set until the next write of the control word.
- R7: Each convert request lasts one cycle. No further request is issued until the done input has been seen for the current channel.
- R8: The cycle after the done for the last channel, the sequence-done output is high for exactly one cycle and busy is low.
- R9: With the trigger enable at 1, a rising edge on the trigger pin starts a sequence after a two-flop synchronizer. With the trigger enable at 0, the pin has no effect.
- R10: If the idle input goes high while run-in-idle is 0, the sequence is aborted: busy drops, no further request is made and no sequence-done pulse occurs. If run-in-idle is 1, the sequence completes normally.
- R11: A start that arrives while a sequence is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word read-back |
| sw_start | input | 1 | Software start strobe, one cycle |
| trig_pin | input | 1 | External trigger pin, asynchronous |
| chip_idle | input | 1 | High while the chip is in its low-power idle state |
| conv_done | input | 1 | Done handshake from the converter core |
| mux_ch | output | 2 | Multiplexer channel being converted |
| conv_req | output | 1 | One-cycle convert request to the converter core |
| busy | output | 1 | High while a sequence is active |
| seq_done | output | 1 | One-cycle pulse after the final channel completes |
| err | output | 1 | Illegal code or refused start |

## Verification
The assertions assume that the converter core raises the done input only for a request it has received. They also assume that the control word is not rewritten while a sequence is running, because the channel bound is latched at start. The stimulus keeps to both rules: it writes the control word only when busy is low, and it pulses done only after it has seen the matching request. The trigger pin is changed only at the inactive clock edge, so the synchronizer delay seen by the bench is a fixed whole number of cycles.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and field positions for the ADC scan sequencer.
// Assumes an 8-bit control word; field positions are fixed by the bench contract.
package adc_seq_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_e;

    localparam int CFG_W      = 8;
    localparam int SEL_W      = 3;
    localparam int BIT_SCAN   = 3;
    localparam int BIT_TRIG   = 4;
    localparam int BIT_IDLRUN = 5;
    localparam int BIT_REFON  = 6;
endpackage

// File: rtl/adc_mode_reg.sv
// Control word register with the legality decode of the channel code.
// Assumes: code values at or above NUM_CH are reserved; the top channel
// shares its pin with the trigger input.
module adc_mode_reg
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [SEL_W-1:0] sel,
    output logic             scan_en,
    output logic             trig_en,
    output logic             idle_run,
    output logic             ref_on,
    output logic             code_bad
);
    localparam logic [SEL_W-1:0] FIRST_RSVD = SEL_W'(NUM_CH);
    localparam logic [SEL_W-1:0] SHARED_CH  = SEL_W'(NUM_CH - 1);
    localparam logic [CFG_W-1:0] WMASK      = CFG_W'((1 << (BIT_REFON + 1)) - 1);

    logic [CFG_W-1:0] cfg_q;

    // Hold the control word; unused upper bits are never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (we) cfg_q <= wdata & WMASK;
    end

    // Split the stored word into fields and flag illegal codes.
    always_comb begin
        rdata    = cfg_q;
        sel      = cfg_q[SEL_W-1:0];
        scan_en  = cfg_q[BIT_SCAN];
        trig_en  = cfg_q[BIT_TRIG];
        idle_run = cfg_q[BIT_IDLRUN];
        ref_on   = cfg_q[BIT_REFON];
        code_bad = (sel >= FIRST_RSVD) || (trig_en && (sel == SHARED_CH));
    end

    // R1
    // A write is visible on the read-back the next cycle.
    wr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata == ($past(wdata) & WMASK)));
endmodule

// File: rtl/adc_trig_sync.sv
// Synchronizes the asynchronous trigger pin and detects its rising edge.
// Assumes the pin is stable for at least two clock cycles between edges.
module adc_trig_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic [SYNC_STAGES:0] chain_q;

    // Shift the pin through the synchronizer plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
    end

    // Rising edge on the synchronized pin.
    always_comb rise = chain_q[SYNC_STAGES-1] && !chain_q[SYNC_STAGES];

    // R9
    // An edge is reported for a single cycle.
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/adc_seq_fsm.sv
// Channel sequencer: issues one request per channel, waits for done,
// steps through a scan and aborts when the chip idles without run-in-idle.
// Assumes done arrives only after a request, and the config is stable while busy.
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            cfg_we,
    input  logic [CH_W-1:0] sel,
    input  logic            scan_en,
    input  logic            ref_on,
    input  logic            code_bad,
    input  logic            idle_run,
    input  logic            chip_idle,
    input  logic            conv_done,
    output logic [CH_W-1:0] ch,
    output logic            conv_req,
    output logic            busy,
    output logic            seq_done,
    output logic            rejected
);
    seq_state_e      state_q;
    logic [CH_W-1:0] ch_q, last_q;
    logic            done_q, rej_q, halt;

    // Conversion is stopped while the chip idles without run-in-idle.
    always_comb halt = chip_idle && !idle_run;

    // Sequencer state, channel counter, done pulse and refusal flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            ch_q    <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cfg_we) rej_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (go && !halt && !code_bad) begin
                        if (!ref_on) begin
                            rej_q <= 1'b1;
                        end else begin
                            state_q <= SEQ_REQ;
                            ch_q    <= scan_en ? '0 : sel;
                            last_q  <= sel;
                            rej_q   <= 1'b0;
                        end
                    end
                end
                SEQ_REQ: begin
                    state_q <= halt ? SEQ_IDLE : SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (halt) begin
                        state_q <= SEQ_IDLE;
                    end else if (conv_done) begin
                        if (ch_q == last_q) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            ch_q    <= ch_q + 1'b1;
                            state_q <= SEQ_REQ;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Drive outputs from state.
    always_comb begin
        ch       = ch_q;
        conv_req = (state_q == SEQ_REQ);
        busy     = (state_q != SEQ_IDLE);
        seq_done = done_q;
        rejected = rej_q;
    end

    // R7
    // A request never lasts more than one cycle.
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R6
    // No request is issued while the reference is off at launch.
    req_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy && !ref_on) |=> !conv_req);

    // R8
    // Sequence-done follows a done handshake and leaves the block idle.
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> ($past(conv_done) && !busy));

    // R3
    // The channel never passes the latched last channel.
    ch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ch <= last_q));

    // R10
    // A stop request while running returns the sequencer to idle.
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && halt) |=> (!busy && !seq_done));
endmodule

// File: rtl/adc_scan_seq.sv
// Top of the ADC channel scan sequencer: control word, trigger synchronizer
// and channel sequencer. Assumes a single clock; trig_pin is asynchronous.
module adc_scan_seq
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             sw_start,
    input  logic             trig_pin,
    input  logic             chip_idle,
    input  logic             conv_done,
    output logic [CH_W-1:0]  mux_ch,
    output logic             conv_req,
    output logic             busy,
    output logic             seq_done,
    output logic             err
);
    logic [SEL_W-1:0] sel;
    logic scan_en, trig_en, idle_run, ref_on, code_bad;
    logic trig_rise, go, rejected;

    adc_mode_reg #(.NUM_CH(NUM_CH)) u_reg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
        .rdata(cfg_rdata), .sel(sel), .scan_en(scan_en), .trig_en(trig_en),
        .idle_run(idle_run), .ref_on(ref_on), .code_bad(code_bad)
    );

    adc_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(trig_pin), .rise(trig_rise)
    );

    // Merge the software strobe with an enabled trigger edge.
    always_comb go = sw_start || (trig_en && trig_rise);

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go(go), .cfg_we(cfg_we),
        .sel(sel[CH_W-1:0]), .scan_en(scan_en), .ref_on(ref_on),
        .code_bad(code_bad), .idle_run(idle_run), .chip_idle(chip_idle),
        .conv_done(conv_done), .ch(mux_ch), .conv_req(conv_req),
        .busy(busy), .seq_done(seq_done), .rejected(rejected)
    );

    // Error output: illegal code now, or a refused start since the last write.
    always_comb err = code_bad || rejected;

    // R4
    // No request starts from idle while the code is illegal.
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && code_bad) |=> !conv_req);
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       sw_start = 1'b0, trig_pin = 1'b0, chip_idle = 1'b0, conv_done = 1'b0;
    logic [1:0] mux_ch;
    logic       conv_req, busy, seq_done, err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    adc_scan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sw_start(sw_start), .trig_pin(trig_pin),
        .chip_idle(chip_idle), .conv_done(conv_done), .mux_ch(mux_ch),
        .conv_req(conv_req), .busy(busy), .seq_done(seq_done), .err(err)
    );

    // Vector: {cfg[7:0], expected request count[2:0], expected err}
    localparam logic [11:0] VEC [12] = '{
        12'h402, 12'h422, 12'h432, 12'h482, 12'h494, 12'h4A6,
        12'h4B8, 12'h451, 12'h4F1, 12'h531, 12'h031, 12'h512
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_wdata = v; cfg_we = 1'b1;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    // Wait up to n negedges for a request; returns whether one was seen.
    task automatic wait_req(input int n, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < n && !seen; i++) begin
            if (conv_req) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    // Answer the pending request with a one-cycle done.
    task automatic give_done();
        @(negedge clk); conv_done = 1'b1;
        @(negedge clk); conv_done = 1'b0;
    endtask

    function automatic string tag_of(input logic [7:0] c);
        if (c[2:0] >= 3'd4) return "R4";
        if (c[4] && c[2:0] == 3'd3) return "R5";
        if (!c[6]) return "R6";
        if (c[3]) return "R3";
        return "R2";
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", cfg_rdata, 8'h00);
        check("R8", {6'd0, busy, seq_done}, 8'h00);
        write_cfg(8'hFF);
        check("R1", cfg_rdata, 8'h7F);

        // Table walk: R2..R6
        for (int v = 0; v < 12; v++) begin
            logic [7:0] c;
            int n;
            c = VEC[v][11:4];
            n = int'(VEC[v][3:1]);
            write_cfg(c);
            pulse_start();
            if (n == 0) begin
                wait_req(5, seen);
                check(tag_of(c), {7'd0, seen}, 8'd0);
                check(tag_of(c), {7'd0, err}, {7'd0, VEC[v][0]});
            end else begin
                for (int k = 0; k < n; k++) begin
                    wait_req(8, seen);
                    check(tag_of(c), {7'd0, seen}, 8'd1);
                    check(tag_of(c), {6'd0, mux_ch}, c[3] ? 8'(k) : {5'd0, c[2:0]});
                    give_done();
                end
                check("R8", {6'd0, seq_done, busy}, 8'h02);
                @(negedge clk);
                check("R8", {7'd0, seq_done}, 8'd0);
                check(tag_of(c), {7'd0, err}, 8'd0);
            end
        end

        // R6: error stays until the next write
        write_cfg(8'h01);
        pulse_start();
        repeat (3) @(negedge clk);
        check("R6", {7'd0, err}, 8'd1);
        write_cfg(8'h41);
        check("R6", {7'd0, err}, 8'd0);

        // R7: request is one cycle and no new one before done
        pulse_start();
        wait_req(8, seen);
        @(negedge clk);
        check("R7", {7'd0, conv_req}, 8'd0);
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (conv_req) seen = 1'b1;
        end
        check("R7", {7'd0, seen}, 8'd0);
        // R11: start while busy is ignored
        pulse_start();
        give_done();
        check("R11", {7'd0, seq_done}, 8'd1);
        wait_req(6, seen);
        check("R11", {7'd0, seen}, 8'd0);

        // R9: trigger edge starts when enabled
        write_cfg(8'h52);
        trig_pin = 1'b1;
        wait_req(8, seen);
        check("R9", {7'd0, seen}, 8'd1);
        check("R9", {6'd0, mux_ch}, 8'd2);
        give_done();
        trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        write_cfg(8'h42);
        trig_pin = 1'b1;
        wait_req(8, seen);
        check("R9", {7'd0, seen}, 8'd0);
        trig_pin = 1'b0;

        // R10: idle without run-in-idle aborts
        write_cfg(8'h4B);
        pulse_start();
        wait_req(8, seen);
        give_done();
        wait_req(8, seen);
        check("R10", {6'd0, mux_ch}, 8'd1);
        chip_idle = 1'b1;
        @(negedge clk);
        check("R10", {7'd0, busy}, 8'd0);
        seen = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (conv_req || seq_done) seen = 1'b1;
        end
        check("R10", {7'd0, seen}, 8'd0);
        // R10: with run-in-idle the scan completes while idle
        write_cfg(8'h6B);
        pulse_start();
        for (int k = 0; k < 4; k++) begin
            wait_req(8, seen);
            check("R10", {6'd0, mux_ch}, 8'(k));
            give_done();
        end
        check("R10", {7'd0, seq_done}, 8'd1);
        chip_idle = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule